// File: doc/BRIEF.md
# Multiplexed register bus slave

This block is an 8-bit register-file slave for a narrow parallel host bus. Address and data share one 8-bit path. A separate select line tells the two phases apart. With the select line high, a host write loads a register index. With it low, reads and writes go to the register named by the stored index. The index stays in place for any number of data accesses; it does not advance on its own.

The block keeps a small set of local registers: an interrupt control byte, a second bus-control byte that drives the stream-output enables and the tuner reset lines, two stream clock dividers, and a read-only revision constant. Accesses to the card-address, card-data, bus-control and PID-table indices are handed to attached sub-blocks through a one-cycle strobe interface.

Chip select and both strobes pass through a two-flop synchroniser. The block acts on the falling edge of each synchronised strobe. It answers with an active-low ready that stays asserted until the host releases the strobe. The host must hold the select line and the write data steady while a strobe is low. When armed, a level change on either card-detect input latches an interrupt. The interrupt holds the active-low interrupt output asserted until the host reads the interrupt register.

Top module: `mxbus_regslave`

## Requirements
- R1: A write with `bus_sel` high stores `bus_din` as the current index. A read with `bus_sel` high returns the current index.
- R2: Data-phase accesses (`bus_sel` low) reach the register at the stored index. The index does not change between accesses.
- R3: Index 0x0F reads the constant `REVISION` (default 0x2A). Writes to it have no effect.
- R4: Index 0x01 is bus control 2 and resets to 0x00. Bit 4 drives `ts_en[0]` and bit 5 drives `ts_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`. Reads return the whole byte.
- R5: Indices 0x0C and 0x0D are read/write divider bytes that drive `div_a` and `div_b`. Both reset to 0x00.
- R6: A data write to any index from 0x04 to 0x0A gives a one-cycle `sub_wr` pulse, with the index on `sub_idx` and the data on `sub_wdata`. A data read in that range gives a one-cycle `sub_rd` pulse and returns `sub_rdata` as sampled in that cycle. Other indices produce no sub-block strobe.
- R7: Indices 0x02, 0x03, 0x0B, 0x0E and 0x10 or higher read as 0x00. Writes to them change nothing.
- R8: `bus_rdy_n` goes low on the third rising clock edge after a strobe falls. It rises on the third rising edge after the strobe is released. During a read, `bus_doe` is high for the same span and `bus_dout` holds the read value.
- R9: While `bus_cs_n` is high, strobes are ignored: no register changes and `bus_rdy_n` stays high.
- R10: Index 0x00 resets to 0x00. Interrupts are armed only while it holds exactly 0x44. When armed, a level change on any `card_det` line sets the pending flag. `bus_irq_n` is the inverse of that flag.
- R11: A data read of index 0x00 returns the stored byte with bit 0 replaced by the pending flag, then clears the flag. Nothing else clears it.
- R12: If a card-detect change and an acknowledging read land in the same cycle, the flag stays set. The read still returns the flag as it stood before the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | High: index phase; low: data phase |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_din | input | 8 | Shared address/data path, host to block |
| bus_dout | output | 8 | Read data, block to host |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_rdy_n | output | 1 | Ready, active low |
| bus_irq_n | output | 1 | Interrupt, active low |
| card_det | input | NCD | Card-detect levels (asynchronous) |
| sub_wr | output | 1 | One-cycle sub-block write strobe |
| sub_rd | output | 1 | One-cycle sub-block read strobe |
| sub_idx | output | 8 | Current register index |
| sub_wdata | output | 8 | Sub-block write data |
| sub_rdata | input | 8 | Sub-block read data, valid for the current index |
| ts_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Tuner resets, active low |
| div_a | output | 8 | Stream clock divider A |
| div_b | output | 8 | Stream clock divider B |

## Verification
A card-detect edge and the read that acknowledges the interrupt can fall in the same clock cycle. The set and the clear then act on the pending flag together. Both inputs pass through synchronisers of equal depth, so the bench toggles a card-detect line on the same falling clock edge that it lowers the read strobe. This places the set and the clear on one edge. The read must return the earlier pending value, and `bus_irq_n` must stay low afterwards. Two further reads then show that the flag clears once and then reads as zero.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  localparam int BUS_W = 8;
  typedef logic [BUS_W-1:0] byte_t;

  localparam byte_t IDX_IRQ    = 8'h00;
  localparam byte_t IDX_CTL2   = 8'h01;
  localparam byte_t IDX_SUB_LO = 8'h04;
  localparam byte_t IDX_SUB_HI = 8'h0A;
  localparam byte_t IDX_DIV_A  = 8'h0C;
  localparam byte_t IDX_DIV_B  = 8'h0D;
  localparam byte_t IDX_REV    = 8'h0F;
  localparam byte_t IRQ_ARM_CODE = 8'h44;

  localparam int CTL2_TS_LSB = 4;
  localparam int CTL2_TUN0   = 3;
  localparam int CTL2_TUN1   = 2;

  typedef enum logic [1:0] {ACC_NONE, ACC_LOCAL, ACC_SUB} acc_kind_e;

  // Decide who owns a register index.
  function automatic acc_kind_e classify(input byte_t idx);
    if (idx >= IDX_SUB_LO && idx <= IDX_SUB_HI) return ACC_SUB;
    case (idx)
      IDX_IRQ, IDX_CTL2, IDX_DIV_A, IDX_DIV_B, IDX_REV: return ACC_LOCAL;
      default: return ACC_NONE;
    endcase
  endfunction

  // Interrupt register as seen by the host: bit 0 carries the pending flag.
  function automatic byte_t irq_view(input byte_t ctl, input logic pend);
    return {ctl[BUS_W-1:1], pend};
  endfunction
endpackage

// File: rtl/mxbus_sync.sv
module mxbus_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mxbus_strobe.sv
module mxbus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic wr_s,
  input  logic rd_s,
  output logic wr_evt,
  output logic rd_evt,
  output logic rdy_n,
  output logic rd_hold
);
  logic wr_d, rd_d, wr_fall, rd_fall;

  always_comb begin
    wr_fall = wr_d & ~wr_s;
    rd_fall = rd_d & ~rd_s;
    wr_evt  = wr_fall & ~cs_s;
    rd_evt  = rd_fall & ~cs_s & ~wr_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d    <= 1'b1;
      rd_d    <= 1'b1;
      rdy_n   <= 1'b1;
      rd_hold <= 1'b0;
    end else begin
      wr_d <= wr_s;
      rd_d <= rd_s;
      if (wr_evt || rd_evt) rdy_n <= 1'b0;
      else if (wr_s && rd_s) rdy_n <= 1'b1;
      if (rd_evt) rd_hold <= 1'b1;
      else if (rd_s) rd_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/mxbus_irq.sv
module mxbus_irq #(
  parameter int NCD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCD-1:0] cd_s,
  input  logic           arm,
  input  logic           ack,
  output logic           irq_set,
  output logic           pend
);
  logic [NCD-1:0] cd_prev, line_chg;

  for (genvar i = 0; i < NCD; i++) begin : g_line
    assign line_chg[i] = cd_s[i] ^ cd_prev[i];
  end

  assign irq_set = arm & (|line_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_prev <= '0;
      pend    <= 1'b0;
    end else begin
      cd_prev <= cd_s;
      if (irq_set)  pend <= 1'b1;   // a new event outranks the acknowledge
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/mxbus_regfile.sv
module mxbus_regfile import mxbus_pkg::*; #(
  parameter byte_t REVISION = 8'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt,
  input  logic       rd_evt,
  input  logic       sel,
  input  byte_t      din,
  input  byte_t      sub_rdata,
  input  logic       irq_pend,
  output byte_t      cur_idx,
  output byte_t      dout,
  output logic       sub_wr,
  output logic       sub_rd,
  output byte_t      sub_wdata,
  output logic       irq_ack,
  output logic       irq_arm,
  output logic [1:0] ts_en,
  output logic [1:0] tuner_rst_n,
  output byte_t      div_a,
  output byte_t      div_b
);
  byte_t     ctl_q, ctl2_q, rd_val;
  acc_kind_e kind;
  logic      data_wr, data_rd;

  always_comb begin
    kind      = classify(cur_idx);
    data_wr   = wr_evt & ~sel;
    data_rd   = rd_evt & ~sel;
    sub_wr    = data_wr && (kind == ACC_SUB);
    sub_rd    = data_rd && (kind == ACC_SUB);
    sub_wdata = din;
    irq_ack   = data_rd && (cur_idx == IDX_IRQ);
    irq_arm   = (ctl_q == IRQ_ARM_CODE);
    rd_val    = '0;
    if (sel) rd_val = cur_idx;
    else if (kind == ACC_SUB) rd_val = sub_rdata;
    else begin
      case (cur_idx)
        IDX_IRQ:   rd_val = irq_view(ctl_q, irq_pend);
        IDX_CTL2:  rd_val = ctl2_q;
        IDX_DIV_A: rd_val = div_a;
        IDX_DIV_B: rd_val = div_b;
        IDX_REV:   rd_val = REVISION;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      ctl_q   <= '0;
      ctl2_q  <= '0;
      div_a   <= '0;
      div_b   <= '0;
      dout    <= '0;
    end else begin
      if (wr_evt && sel) cur_idx <= din;
      if (data_wr) begin
        case (cur_idx)
          IDX_IRQ:   ctl_q  <= din;
          IDX_CTL2:  ctl2_q <= din;
          IDX_DIV_A: div_a  <= din;
          IDX_DIV_B: div_b  <= din;
          default: ;
        endcase
      end
      if (rd_evt) dout <= rd_val;
    end
  end

  assign ts_en       = ctl2_q[CTL2_TS_LSB +: 2];
  assign tuner_rst_n = {ctl2_q[CTL2_TUN1], ctl2_q[CTL2_TUN0]};
endmodule

// File: rtl/mxbus_regslave.sv
module mxbus_regslave import mxbus_pkg::*; #(
  parameter int    SYNC_STAGES = 2,
  parameter int    NCD         = 2,
  parameter byte_t REVISION    = 8'h2A
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_cs_n,
  input  logic           bus_sel,
  input  logic           bus_wr_n,
  input  logic           bus_rd_n,
  input  logic [7:0]     bus_din,
  output logic [7:0]     bus_dout,
  output logic           bus_doe,
  output logic           bus_rdy_n,
  output logic           bus_irq_n,
  input  logic [NCD-1:0] card_det,
  output logic           sub_wr,
  output logic           sub_rd,
  output logic [7:0]     sub_idx,
  output logic [7:0]     sub_wdata,
  input  logic [7:0]     sub_rdata,
  output logic [1:0]     ts_en,
  output logic [1:0]     tuner_rst_n,
  output logic [7:0]     div_a,
  output logic [7:0]     div_b
);
  localparam int NSTRB = 3;

  logic [NSTRB-1:0] strb_s;
  logic [NCD-1:0]   cd_s;
  logic cs_s, wr_s, rd_s;
  logic wr_evt, rd_evt, irq_ack, irq_arm, irq_set, irq_pend;
  byte_t cur_idx;

  mxbus_sync #(.W(NSTRB), .STAGES(SYNC_STAGES), .RST_VAL({NSTRB{1'b1}})) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({bus_cs_n, bus_wr_n, bus_rd_n}), .q(strb_s));

  mxbus_sync #(.W(NCD), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_cd (
    .clk(clk), .rst_n(rst_n), .d(card_det), .q(cd_s));

  assign cs_s = strb_s[2];
  assign wr_s = strb_s[1];
  assign rd_s = strb_s[0];

  mxbus_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .wr_s(wr_s), .rd_s(rd_s),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .rdy_n(bus_rdy_n), .rd_hold(bus_doe));

  mxbus_regfile #(.REVISION(REVISION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .sel(bus_sel),
    .din(bus_din), .sub_rdata(sub_rdata), .irq_pend(irq_pend),
    .cur_idx(cur_idx), .dout(bus_dout), .sub_wr(sub_wr), .sub_rd(sub_rd),
    .sub_wdata(sub_wdata), .irq_ack(irq_ack), .irq_arm(irq_arm),
    .ts_en(ts_en), .tuner_rst_n(tuner_rst_n), .div_a(div_a), .div_b(div_b));

  mxbus_irq #(.NCD(NCD)) u_irq (
    .clk(clk), .rst_n(rst_n), .cd_s(cd_s), .arm(irq_arm), .ack(irq_ack),
    .irq_set(irq_set), .pend(irq_pend));

  assign sub_idx   = cur_idx;
  assign bus_irq_n = ~irq_pend;
endmodule

// File: rtl/mxbus_regslave_chk.sv
module mxbus_regslave_chk import mxbus_pkg::*; #(
  parameter byte_t REVISION = 8'h2A
) (
  input logic  clk,
  input logic  rst_n,
  input logic  wr_evt,
  input logic  rd_evt,
  input logic  bus_sel,
  input byte_t bus_din,
  input byte_t bus_dout,
  input byte_t cur_idx,
  input logic  bus_rdy_n,
  input logic  bus_irq_n,
  input logic  irq_ack,
  input logic  irq_set,
  input logic  sub_wr,
  input logic  sub_rd
);
  assert_rdy_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt || rd_evt) |=> !bus_rdy_n);

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_sel) |=> (cur_idx == $past(bus_din)));

  assert_rev_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !bus_sel && cur_idx == IDX_REV) |=> (bus_dout == REVISION));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !bus_sel && classify(cur_idx) == ACC_NONE) |=> (bus_dout == '0));

  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irq_n && !irq_ack) |=> !bus_irq_n);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !bus_irq_n);

  assert_sub_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_wr, sub_rd}));
endmodule

bind mxbus_regslave mxbus_regslave_chk #(.REVISION(REVISION)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt), .bus_sel(bus_sel),
  .bus_din(bus_din), .bus_dout(bus_dout), .cur_idx(cur_idx), .bus_rdy_n(bus_rdy_n),
  .bus_irq_n(bus_irq_n), .irq_ack(irq_ack), .irq_set(irq_set),
  .sub_wr(sub_wr), .sub_rd(sub_rd));

// File: tb/mxbus_regslave_test.sv
`timescale 1ns/1ps
module mxbus_regslave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1, bus_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic bus_doe, bus_rdy_n, bus_irq_n;
  logic [1:0] card_det = 2'b00;
  logic sub_wr, sub_rd;
  logic [7:0] sub_idx, sub_wdata, sub_rdata;
  logic [1:0] ts_en, tuner_rst_n;
  logic [7:0] div_a, div_b;

  int n_tests = 0;
  int n_fail = 0;
  int sub_wr_cnt = 0;
  int sub_rd_cnt = 0;
  logic [7:0] last_sub_idx = 8'h00;
  logic [7:0] last_sub_wdata = 8'h00;

  always #5 clk = ~clk;

  // sub-block model: read data depends only on the index
  assign sub_rdata = 8'h5A ^ sub_idx;

  mxbus_regslave uut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_sel(bus_sel),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n),
    .bus_irq_n(bus_irq_n), .card_det(card_det), .sub_wr(sub_wr),
    .sub_rd(sub_rd), .sub_idx(sub_idx), .sub_wdata(sub_wdata),
    .sub_rdata(sub_rdata), .ts_en(ts_en), .tuner_rst_n(tuner_rst_n),
    .div_a(div_a), .div_b(div_b));

  always @(negedge clk) begin
    if (sub_wr) begin sub_wr_cnt++; last_sub_idx = sub_idx; last_sub_wdata = sub_wdata; end
    if (sub_rd) begin sub_rd_cnt++; last_sub_idx = sub_idx; end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk(req, {7'b0, act}, {7'b0, exp});
  endtask

  task automatic wait_rdy(input logic lvl);
    int n = 0;
    while (bus_rdy_n !== lvl && n < 40) begin @(negedge clk); n++; end
    if (bus_rdy_n !== lvl) chk1("R8 rdy timeout", bus_rdy_n, lvl);
  endtask

  task automatic bus_access(input logic is_rd, input logic sel, input logic [7:0] wdat,
                            output logic [7:0] rdat);
    @(negedge clk); bus_cs_n = 1'b0; bus_sel = sel; bus_din = wdat;
    @(negedge clk); if (is_rd) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
    @(negedge clk); wait_rdy(1'b0);
    rdat = bus_dout;
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk); wait_rdy(1'b1);
    bus_cs_n = 1'b1;
  endtask

  task automatic wr_idx(input logic [7:0] i);
    logic [7:0] d;
    bus_access(1'b0, 1'b1, i, d);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
    logic [7:0] d;
    wr_idx(i);
    bus_access(1'b0, 1'b0, v, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    wr_idx(i);
    bus_access(1'b1, 1'b0, 8'h00, v);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk1("R8 reset rdy_n", bus_rdy_n, 1'b1);
    chk1("R8 reset doe", bus_doe, 1'b0);
    chk1("R10 reset irq_n", bus_irq_n, 1'b1);
    chk("R4 reset ts_en", {6'b0, ts_en}, 8'h00);
    chk("R4 reset tuner_rst_n", {6'b0, tuner_rst_n}, 8'h00);
    chk("R5 reset div_a", div_a, 8'h00);
    chk("R5 reset div_b", div_b, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] v;
    wr_idx(8'h0C);
    bus_access(1'b1, 1'b1, 8'h00, v);
    chk("R1 index readback", v, 8'h0C);
  endtask

  task automatic t_div;
    logic [7:0] v;
    wr_reg(8'h0C, 8'h37);
    wr_reg(8'h0D, 8'hC4);
    chk("R5 div_a", div_a, 8'h37);
    chk("R5 div_b", div_b, 8'hC4);
    rd_reg(8'h0C, v);
    chk("R5 div_a readback", v, 8'h37);
    bus_access(1'b1, 1'b0, 8'h00, v);
    chk("R2 repeat read same index", v, 8'h37);
    bus_access(1'b0, 1'b0, 8'h21, v);
    chk("R2 second write same index", div_a, 8'h21);
    chk("R2 neighbour untouched", div_b, 8'hC4);
    bus_access(1'b1, 1'b1, 8'h00, v);
    chk("R2 index kept", v, 8'h0C);
    wr_reg(8'h0C, 8'h37);
  endtask

  task automatic t_ctl2;
    logic [7:0] v;
    wr_reg(8'h01, 8'h38);
    chk("R4 ts_en 0x38", {6'b0, ts_en}, 8'h03);
    chk("R4 tuner 0x38", {6'b0, tuner_rst_n}, 8'h01);
    wr_reg(8'h01, 8'h14);
    chk("R4 ts_en 0x14", {6'b0, ts_en}, 8'h01);
    chk("R4 tuner 0x14", {6'b0, tuner_rst_n}, 8'h02);
    rd_reg(8'h01, v);
    chk("R4 readback", v, 8'h14);
  endtask

  task automatic t_rev;
    logic [7:0] v;
    rd_reg(8'h0F, v);
    chk("R3 revision", v, 8'h2A);
    wr_reg(8'h0F, 8'hFF);
    rd_reg(8'h0F, v);
    chk("R3 revision after write", v, 8'h2A);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    logic [7:0] idxs [6] = '{8'h02, 8'h03, 8'h0B, 8'h0E, 8'h10, 8'hFF};
    int w0 = sub_wr_cnt;
    int r0 = sub_rd_cnt;
    foreach (idxs[k]) begin
      wr_reg(idxs[k], 8'hA5);
      rd_reg(idxs[k], v);
      chk($sformatf("R7 unmapped 0x%02h", idxs[k]), v, 8'h00);
    end
    chk("R7 no sub strobe", 8'(sub_wr_cnt - w0 + sub_rd_cnt - r0), 8'h00);
    chk("R7 div_a intact", div_a, 8'h37);
    chk("R7 ctl2 intact", {6'b0, ts_en}, 8'h01);
  endtask

  task automatic t_sub;
    logic [7:0] v;
    int w0 = sub_wr_cnt;
    int r0 = sub_rd_cnt;
    wr_reg(8'h06, 8'h9B);
    chk("R6 sub_wr count", 8'(sub_wr_cnt - w0), 8'h01);
    chk("R6 sub_idx", last_sub_idx, 8'h06);
    chk("R6 sub_wdata", last_sub_wdata, 8'h9B);
    rd_reg(8'h0A, v);
    chk("R6 read 0x0A", v, 8'h5A ^ 8'h0A);
    rd_reg(8'h04, v);
    chk("R6 read 0x04", v, 8'h5A ^ 8'h04);
    chk("R6 sub_rd count", 8'(sub_rd_cnt - r0), 8'h02);
  endtask

  task automatic t_rdy_timing;
    wr_idx(8'h0C);
    @(negedge clk); bus_cs_n = 1'b0; bus_sel = 1'b0;
    @(negedge clk); bus_rd_n = 1'b0;
    idle(2);
    chk1("R8 rdy high after 2 edges", bus_rdy_n, 1'b1);
    idle(1);
    chk1("R8 rdy low after 3 edges", bus_rdy_n, 1'b0);
    chk1("R8 doe during read", bus_doe, 1'b1);
    chk("R8 dout during read", bus_dout, 8'h37);
    bus_rd_n = 1'b1;
    idle(2);
    chk1("R8 rdy held 2 edges after release", bus_rdy_n, 1'b0);
    idle(1);
    chk1("R8 rdy released 3 edges", bus_rdy_n, 1'b1);
    chk1("R8 doe off", bus_doe, 1'b0);
    bus_cs_n = 1'b1;
  endtask

  task automatic t_cs_ignored;
    logic [7:0] v;
    logic seen_low = 1'b0;
    @(negedge clk); bus_cs_n = 1'b1; bus_sel = 1'b1; bus_din = 8'h02; bus_wr_n = 1'b0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (!bus_rdy_n) seen_low = 1'b1; end
    bus_wr_n = 1'b1; bus_sel = 1'b0; bus_din = 8'h99; bus_rd_n = 1'b0;
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (!bus_rdy_n) seen_low = 1'b1; end
    bus_rd_n = 1'b1;
    idle(4);
    chk1("R9 no ready with cs high", seen_low, 1'b0);
    bus_access(1'b1, 1'b1, 8'h00, v);
    chk("R9 index unchanged", v, 8'h0C);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    card_det[0] = ~card_det[0]; idle(6);
    chk1("R10 disarmed ignores change", bus_irq_n, 1'b1);
    wr_reg(8'h00, 8'h40);
    card_det[0] = ~card_det[0]; idle(6);
    chk1("R10 wrong code ignores change", bus_irq_n, 1'b1);
    rd_reg(8'h00, v);
    chk("R11 read with no pending", v, 8'h40);
    wr_reg(8'h00, 8'h44);
    card_det[1] = ~card_det[1]; idle(6);
    chk1("R10 armed change raises irq", bus_irq_n, 1'b0);
    idle(20);
    chk1("R11 irq held", bus_irq_n, 1'b0);
    rd_reg(8'h00, v);
    chk("R11 read shows pending", v, 8'h45);
    chk1("R11 read clears irq", bus_irq_n, 1'b1);
    rd_reg(8'h00, v);
    chk("R11 read after clear", v, 8'h44);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    card_det[0] = ~card_det[0]; idle(6);
    chk1("R12 setup pending", bus_irq_n, 1'b0);
    wr_idx(8'h00);
    @(negedge clk); bus_cs_n = 1'b0; bus_sel = 1'b0;
    @(negedge clk); bus_rd_n = 1'b0; card_det[0] = ~card_det[0];
    @(negedge clk); wait_rdy(1'b0);
    v = bus_dout;
    bus_rd_n = 1'b1;
    @(negedge clk); wait_rdy(1'b1);
    bus_cs_n = 1'b1;
    chk("R12 read value on collision", v, 8'h45);
    chk1("R12 irq kept after collision", bus_irq_n, 1'b0);
    bus_access(1'b1, 1'b0, 8'h00, v);
    chk("R12 next read pending", v, 8'h45);
    chk1("R12 then cleared", bus_irq_n, 1'b1);
    bus_access(1'b1, 1'b0, 8'h00, v);
    chk("R12 final read", v, 8'h44);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_index();
    t_div();
    t_ctl2();
    t_rev();
    t_unmapped();
    t_sub();
    t_rdy_timing();
    t_cs_ignored();
    t_irq();
    t_collide();
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule